// File: doc/BRIEF.md
# Bank Translation Unit with Per-Process Isolation

This block sits between a CPU with a 24-bit address bus and its physical memory. The upper eight address bits select a 64 KiB bank. The unit replaces the CPU's virtual bank with a physical bank that it looks up in a mapping table. The table index joins the active process identifier with the virtual bank, so each process sees its own private set of banks. A second table, indexed the same way, holds access rights. When a process touches a bank it may not use, or writes to a bank it may only read, the unit raises an abort in the same cycle, so the offending instruction can be cancelled before it changes any data.

The unit also decides whether the CPU is privileged. The CPU is privileged when the process identifier is zero, when an interrupt service routine is running, or when the current process's rights entry for bank 0xFF grants elevation. Only a privileged CPU may change the process register or either table. These writes go through a small configuration port. An interrupt routine can switch between two processes by flipping bit 0 of the process register.

The process identifier width is a parameter. The full-size setting is seven bits, which gives 32K entries per table. The default is smaller so the tables stay small during elaboration.

Top module: `bank_mmu`

## Requirements
- R1: After reset the process register is 0, every mapping entry is 0x00 and every rights entry is 0. So `phys_bank` reads 0x00, `priv` is 1 and `abort` is 0.
- R2: `phys_bank` equals the mapping entry at index {process register, `cpu_bank`}. It follows a change of bank or process in the same cycle.
- R3: While the process register is 0, `priv` is 1.
- R4: While `cpu_isr` is 1, `priv` is 1.
- R5: While the rights entry at {process register, 0xFF} has bit 2 (elevate) set, `priv` is 1. Otherwise, with a nonzero process and `cpu_isr` low, `priv` is 0.
- R6: When unprivileged and `cpu_vda` is 1, `abort` is 1 if the rights entry for the current index has bit 0 (valid) clear.
- R7: When unprivileged and `cpu_vda` is 1 with `cpu_rw` = 0 (write), `abort` is 1 if the rights entry has bit 1 (write-enable) clear. A read (`cpu_rw` = 1) of a valid entry never aborts.
- R8: `abort` is 0 whenever `cpu_vda` is 0 or `priv` is 1.
- R9: A configuration write (`cfg_we` = 1) takes effect at the clock edge only if `priv` is 1 in that cycle. Otherwise it changes nothing. `cfg_sel` chooses the target: 0 = process register (low bits of `cfg_data`), 1 = mapping entry at `cfg_idx`, 2 = rights entry at `cfg_idx` (`cfg_data[2:0]`), 3 = no target.
- R10: Rewriting the process register with only bit 0 changed moves every translation, rights lookup and privilege decision to the other process's entries from the next cycle.
- R11: `abort` is combinational. It is high only in the cycles in which the offending access is present on the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_bank | input | BANK_W | Virtual bank (upper address bits) |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_vda | input | 1 | Valid data address this cycle |
| cpu_isr | input | 1 | Interrupt service routine active |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_idx | input | PID_W+BANK_W | Table index for configuration write |
| cfg_data | input | BANK_W | Configuration write data |
| phys_bank | output | BANK_W | Translated physical bank |
| abort | output | 1 | Illegal access in this cycle |
| priv | output | 1 | CPU currently privileged |

## Verification
The bench first uses directed accesses to separate the cases. It reads a valid entry, reads an invalid entry, writes to a read-only entry, and repeats the illegal accesses with `cpu_vda` low, with `cpu_isr` high and from an elevated process. This separates rights decoding from privilege masking. It then tries configuration writes from an unprivileged process and observes the unchanged translation, privilege and abort at the ports. This shows that the privilege gate is really applied to writes. Finally a long random mix of banks, directions, interrupt flags and configuration writes, including writes that change the process register, is compared every cycle against a behavioural model. This exposes errors in index formation and in how the process register and the tables interact.

// File: rtl/mmu_pkg.sv
// Shared types of the bank translation unit.
// Assumes: rights fields are packed with valid in bit 0.
package mmu_pkg;
    typedef enum logic [1:0] {
        CFG_PID  = 2'd0,
        CFG_MAP  = 2'd1,
        CFG_PERM = 2'd2,
        CFG_NONE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic elevate;   // bit 2: grants privilege when held at bank 0xFF
        logic wr_ok;     // bit 1: writes allowed
        logic valid;     // bit 0: bank may be accessed
    } perm_t;

    localparam int PERM_W = $bits(perm_t);
endpackage

// File: rtl/mmu_pid_reg.sv
// Process identifier register.
// Assumes: the write enable is already qualified by privilege.
module mmu_pid_reg #(
    parameter int PID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PID_W-1:0] d,
    output logic [PID_W-1:0] q
);
    // Hold the active process, cleared to process 0 by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/mmu_table.sv
// Table with one write port and RD_PORTS combinational read ports.
// Assumes: the write enable is already qualified by privilege; reset clears all entries.
module mmu_table #(
    parameter int W        = 8,
    parameter int IDX_W    = 10,
    parameter int RD_PORTS = 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [W-1:0]                   wr_data,
    input  logic [RD_PORTS-1:0][IDX_W-1:0] rd_idx,
    output logic [RD_PORTS-1:0][W-1:0]     rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [W-1:0] mem [DEPTH];

    // Store entries; reset clears every one of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // One asynchronous read per requested port.
    for (genvar g = 0; g < RD_PORTS; g++) begin : g_rd
        assign rd_data[g] = mem[rd_idx[g]];
    end
endmodule

// File: rtl/mmu_priv_check.sv
// Privilege decision and abort generation, purely combinational.
// Assumes: cur_perm belongs to the accessed bank, top_perm to bank 0xFF of the same process.
module mmu_priv_check
    import mmu_pkg::*;
#(
    parameter int PID_W = 2
) (
    input  logic [PID_W-1:0] pid,
    input  logic             isr,
    input  perm_t            top_perm,
    input  perm_t            cur_perm,
    input  logic             vda,
    input  logic             rw,
    output logic             priv,
    output logic             abort
);
    logic bad_access;

    // Privileged when process 0, in an interrupt, or elevated by the bank 0xFF entry.
    always_comb priv = (pid == '0) | isr | top_perm.elevate;

    // Access is illegal on an invalid entry or on a write to a read-only entry.
    always_comb bad_access = !cur_perm.valid | (!rw & !cur_perm.wr_ok);

    // Abort only for a real access made without privilege.
    always_comb abort = vda & !priv & bad_access;
endmodule

// File: rtl/bank_mmu.sv
// Bank translation unit: maps {process, virtual bank} to a physical bank,
// checks access rights and decides privilege. Configuration writes are
// accepted only while privileged.
// Assumes: PID_W <= BANK_W and PERM_W <= BANK_W.
module bank_mmu
    import mmu_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int PID_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [BANK_W-1:0]       cpu_bank,
    input  logic                    cpu_rw,
    input  logic                    cpu_vda,
    input  logic                    cpu_isr,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_sel,
    input  logic [PID_W+BANK_W-1:0] cfg_idx,
    input  logic [BANK_W-1:0]       cfg_data,
    output logic [BANK_W-1:0]       phys_bank,
    output logic                    abort,
    output logic                    priv
);
    localparam int IDX_W = PID_W + BANK_W;
    localparam logic [BANK_W-1:0] TOP_BANK = '1;

    logic [PID_W-1:0] pid_q;
    logic             cfg_ok;
    logic             pid_we, map_we, perm_we;
    logic [IDX_W-1:0] cur_idx, top_idx;
    perm_t            cur_perm, top_perm;

    logic [0:0][IDX_W-1:0]        map_rd_idx;
    logic [0:0][BANK_W-1:0]       map_rd_data;
    logic [1:0][IDX_W-1:0]        perm_rd_idx;
    logic [1:0][PERM_W-1:0]       perm_rd_data;

    // Form the lookup indices for the accessed bank and for bank 0xFF.
    always_comb begin
        cur_idx = {pid_q, cpu_bank};
        top_idx = {pid_q, TOP_BANK};
    end

    // Gate configuration writes by privilege and decode the target.
    always_comb begin
        cfg_ok  = cfg_we & priv;
        pid_we  = cfg_ok & (cfg_sel == CFG_PID);
        map_we  = cfg_ok & (cfg_sel == CFG_MAP);
        perm_we = cfg_ok & (cfg_sel == CFG_PERM);
    end

    mmu_pid_reg #(.PID_W(PID_W)) u_pid (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pid_we),
        .d     (cfg_data[PID_W-1:0]),
        .q     (pid_q)
    );

    // Route the read indices to the two tables.
    always_comb begin
        map_rd_idx[0]  = cur_idx;
        perm_rd_idx[0] = cur_idx;
        perm_rd_idx[1] = top_idx;
    end

    mmu_table #(.W(BANK_W), .IDX_W(IDX_W), .RD_PORTS(1)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (map_we),
        .wr_idx  (cfg_idx),
        .wr_data (cfg_data),
        .rd_idx  (map_rd_idx),
        .rd_data (map_rd_data)
    );

    mmu_table #(.W(PERM_W), .IDX_W(IDX_W), .RD_PORTS(2)) u_perm (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (perm_we),
        .wr_idx  (cfg_idx),
        .wr_data (cfg_data[PERM_W-1:0]),
        .rd_idx  (perm_rd_idx),
        .rd_data (perm_rd_data)
    );

    // Unpack the rights entries and drive the translated bank.
    always_comb begin
        cur_perm  = perm_t'(perm_rd_data[0]);
        top_perm  = perm_t'(perm_rd_data[1]);
        phys_bank = map_rd_data[0];
    end

    mmu_priv_check #(.PID_W(PID_W)) u_chk_logic (
        .pid      (pid_q),
        .isr      (cpu_isr),
        .top_perm (top_perm),
        .cur_perm (cur_perm),
        .vda      (cpu_vda),
        .rw       (cpu_rw),
        .priv     (priv),
        .abort    (abort)
    );
endmodule

// File: rtl/mmu_checker.sv
// Temporal checks on the bank translation unit, bound into bank_mmu.
// Assumes: synchronous active-low reset.
module mmu_checker
    import mmu_pkg::*;
#(
    parameter int PID_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PID_W-1:0] pid_q,
    input perm_t            cur_perm,
    input logic             cpu_rw,
    input logic             cpu_vda,
    input logic             cpu_isr,
    input logic             cfg_we,
    input logic             abort,
    input logic             priv
);
    // R8
    abort_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (cpu_vda && !priv));

    // R3
    pid_zero_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pid_q == '0) |-> priv);

    // R4
    isr_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_isr |-> priv);

    // R9
    locked_pid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !priv) |=> $stable(pid_q));

    // R7
    valid_read_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rw && cur_perm.valid) |-> !abort);
endmodule

bind bank_mmu mmu_checker #(.PID_W(PID_W)) u_mmu_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .pid_q    (pid_q),
    .cur_perm (cur_perm),
    .cpu_rw   (cpu_rw),
    .cpu_vda  (cpu_vda),
    .cpu_isr  (cpu_isr),
    .cfg_we   (cfg_we),
    .abort    (abort),
    .priv     (priv)
);

// File: tb/tb_bank_mmu.sv
module tb_bank_mmu;
    localparam int BW  = 8;
    localparam int PW  = 2;
    localparam int IW  = PW + BW;
    localparam int ENT = 1 << IW;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [BW-1:0] cpu_bank = '0;
    logic          cpu_rw = 1;
    logic          cpu_vda = 0;
    logic          cpu_isr = 0;
    logic          cfg_we = 0;
    logic [1:0]    cfg_sel = '0;
    logic [IW-1:0] cfg_idx = '0;
    logic [BW-1:0] cfg_data = '0;
    logic [BW-1:0] phys_bank;
    logic          abort;
    logic          priv;

    int    checks = 0;
    int    fails = 0;
    bit    chk_en = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Behavioural model state
    int m_map  [ENT];
    int m_perm [ENT];
    int m_pid;

    bank_mmu #(.BANK_W(BW), .PID_W(PW)) dut (.*);

    always #4 clk = ~clk;

    function automatic bit m_priv();
        return (m_pid == 0) || cpu_isr || m_perm[m_pid * 256 + 255][2];
    endfunction

    // Model update at each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENT; i++) begin m_map[i] = 0; m_perm[i] = 0; end
            m_pid = 0;
        end else if (cfg_we && m_priv()) begin
            case (cfg_sel)
                2'd0: m_pid = cfg_data % (1 << PW);
                2'd1: m_map[cfg_idx] = cfg_data;
                2'd2: m_perm[cfg_idx] = cfg_data % 8;
                default: ;
            endcase
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (chk_en) begin
            int idx, e_bank;
            bit e_priv, e_abort;
            idx     = m_pid * 256 + cpu_bank;
            e_bank  = m_map[idx];
            e_priv  = m_priv();
            e_abort = cpu_vda && !e_priv &&
                      (!m_perm[idx][0] || (!cpu_rw && !m_perm[idx][1]));
            checks += 3;
            if (phys_bank !== e_bank[BW-1:0]) begin
                fails++;
                $display("FAIL %s phys_bank got %h expected %h", cur_req, phys_bank, e_bank[BW-1:0]);
            end
            if (priv !== e_priv) begin
                fails++;
                $display("FAIL %s priv got %b expected %b", cur_req, priv, e_priv);
            end
            if (abort !== e_abort) begin
                fails++;
                $display("FAIL %s abort got %b expected %b", cur_req, abort, e_abort);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic cfg(input logic [1:0] s, input int idx, input int data);
        cfg_we = 1; cfg_sel = s; cfg_idx = idx[IW-1:0]; cfg_data = data[BW-1:0];
        cpu_vda = 0;
        step();
        cfg_we = 0;
    endtask

    task automatic acc(input int bank, input logic rw, input logic vda);
        cpu_bank = bank[BW-1:0]; cpu_rw = rw; cpu_vda = vda;
        step();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step();
        chk_en = 1;
        cur_req = "R1";
        step(); step();
        rst_n = 1;
        step();

        cur_req = "R2";
        cfg(2'd1, 1*256 + 8'h00, 8'h21);
        cfg(2'd1, 1*256 + 8'h05, 8'h35);
        cfg(2'd1, 1*256 + 8'h10, 8'h44);
        cfg(2'd1, 0*256 + 8'h00, 8'h11);
        cfg(2'd1, 2*256 + 8'h00, 8'h52);
        cfg(2'd1, 3*256 + 8'h00, 8'h63);
        cfg(2'd2, 1*256 + 8'h00, 3);
        cfg(2'd2, 1*256 + 8'h05, 1);
        cfg(2'd2, 2*256 + 8'hFF, 4);
        cfg(2'd2, 2*256 + 8'h00, 1);
        cfg(2'd2, 3*256 + 8'h00, 3);
        cur_req = "R3";
        acc(8'h00, 1, 1);
        acc(8'h10, 0, 1);
        cfg(2'd0, 0, 1);
        cur_req = "R2";
        acc(8'h00, 1, 1);
        acc(8'h05, 1, 1);
        cur_req = "R6";
        acc(8'h10, 1, 1);
        cur_req = "R8";
        acc(8'h10, 1, 0);
        cur_req = "R7";
        acc(8'h05, 0, 1);
        acc(8'h00, 0, 1);
        acc(8'h05, 1, 1);
        cur_req = "R11";
        acc(8'h10, 0, 1);
        acc(8'h10, 0, 0);
        acc(8'h00, 1, 1);

        cur_req = "R9";
        cfg(2'd1, 1*256 + 8'h00, 8'h77);
        cfg(2'd0, 0, 0);
        cfg(2'd2, 1*256 + 8'h10, 7);
        cfg(2'd2, 1*256 + 8'hFF, 4);
        acc(8'h00, 1, 1);
        acc(8'h10, 1, 1);
        acc(8'h05, 0, 1);

        cur_req = "R4";
        cpu_isr = 1;
        acc(8'h10, 0, 1);
        cfg(2'd0, 0, 2);
        cpu_isr = 0;
        cur_req = "R5";
        acc(8'h00, 1, 1);
        acc(8'h10, 0, 1);
        cur_req = "R10";
        cfg(2'd0, 0, 3);
        acc(8'h00, 0, 1);
        acc(8'h05, 1, 1);
        cpu_isr = 1;
        cfg(2'd0, 0, 2);
        cpu_isr = 0;
        acc(8'h00, 0, 1);

        cur_req = "random R2 R6 R7 R9";
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom % 5;
            cpu_bank = (r == 0) ? 8'h00 : (r == 1) ? 8'h05 : (r == 2) ? 8'h10 :
                       (r == 3) ? 8'hFF : 8'($urandom);
            cpu_rw   = 1'($urandom);
            cpu_vda  = 1'($urandom);
            cpu_isr  = ($urandom % 8) == 0;
            cfg_we   = ($urandom % 6) == 0;
            cfg_sel  = 2'($urandom);
            cfg_idx  = IW'($urandom);
            cfg_data = BW'($urandom);
            step();
        end
        cfg_we = 0; cpu_vda = 0; cpu_isr = 0;
        step();

        done = 1;
        chk_en = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule